// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash. Once software has issued a program or erase command to the flash, it pulses `start` together with an address. For an erase, the address must fall inside the sector being erased. The poller then reads that address over and over through a simple synchronous read port (request, acknowledge, data) until it can decide whether the embedded operation has ended and whether it succeeded.

The poller makes its decision from a status bit that inverts on every read while the flash is busy. It also uses an error bit that the flash raises on an internal time-out or on a failed program or erase. Each round reads twice and compares the toggle bit between the two reads. A steady toggle bit means the operation has finished. If the bit toggled and the error bit is set, one more read settles the result, so a late completion is not mistaken for a failure. A poll budget, set by a parameter, stops the loop with a separate timeout flag if the flash never settles.

Top module: `fl_toggle_poll`

## Requirements
- R1: While `rst` is high, `rd_req`, `busy`, `done`, `pass_fail` and `timeout` are 0 and `poll_count` is 0.
- R2: A `start` seen while idle latches `start_addr`. `rd_addr` carries that address for every read of the run. `rd_req` stays high until a cycle with `rd_ack` high, and each cycle with both `rd_req` and `rd_ack` high captures `rd_data` as exactly one read.
- R3: A `start` that arrives while `busy` is high is ignored: the address is unchanged, the run continues, and no extra read is issued.
- R4: Within a round, the first read is followed by a second. If bit 6 of `rd_data` is equal in the two reads, the run ends with `pass_fail` = 1.
- R5: If bit 6 differs between the first and second reads of a round and bit 5 of the second read is 0, a new round of two reads begins.
- R6: If bit 6 differs and bit 5 of the second read is 1, a third read follows. The run passes (`pass_fail` = 1) if its bit 6 equals that of the second read, and otherwise fails (`pass_fail` = 0, `timeout` = 0).
- R7: `poll_count` is cleared on a start, rises by one for each captured read, and holds its final value after the run ends.
- R8: When a captured read brings `poll_count` to `MAX_POLLS` and would otherwise lead to another read, the run ends with `pass_fail` = 0 and `timeout` = 1. `poll_count` never exceeds `MAX_POLLS`.
- R9: `done` is high for exactly one cycle, the cycle after the deciding read is captured, and `busy` falls in that same cycle. `pass_fail` and `timeout` keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, taken only when idle |
| start_addr | input | ADDR_W | Address to poll, latched at launch |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | ADDR_W | Address of the read |
| rd_ack | input | 1 | Read acknowledge; data valid in this cycle |
| rd_data | input | DATA_W | Read data byte |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass_fail | output | 1 | 1 = operation passed, 0 = failed or timed out |
| timeout | output | 1 | Run ended because the poll budget ran out |
| poll_count | output | CNT_W | Reads captured in the current or last run |

## Verification
The bench builds the block with `MAX_POLLS` = 12 and `CNT_W` = 8. This lets a flash that never stops toggling run out of budget within a few rounds, at both the second read of a round and just before a confirming read would have been issued. The memory model inverts bit 6 for a chosen number of reads, raises bit 5 from a chosen read onward, and varies the acknowledge latency. This reaches immediate completion, completion inside a confirming read, confirmed failure, and restart attempts during a run.

// File: rtl/fl_poll_pkg.sv
package fl_poll_pkg;

    typedef enum logic [1:0] {
        PST_IDLE    = 2'd0,
        PST_FIRST   = 2'd1,
        PST_SECOND  = 2'd2,
        PST_CONFIRM = 2'd3
    } poll_state_e;

    typedef enum logic [1:0] {
        VD_READ_ON = 2'd0,
        VD_PASS    = 2'd1,
        VD_FAIL    = 2'd2,
        VD_TIMEOUT = 2'd3
    } poll_verdict_e;

    typedef struct packed {
        logic tog;
        logic err;
    } poll_sample_t;

    function automatic logic sample_flipped(poll_sample_t a, poll_sample_t b);
        return a.tog ^ b.tog;
    endfunction

    function automatic logic verdict_final(poll_verdict_e v);
        return v != VD_READ_ON;
    endfunction

endpackage

// File: rtl/fl_poll_rdport.sv
module fl_poll_rdport
    import fl_poll_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 8,
    parameter int TOG_POS = 6,
    parameter int ERR_POS = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              reading,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              hit,
    output poll_sample_t      sample
);

    logic [ADDR_W-1:0] addr_q;
    logic              unused_data_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
        end
    end

    assign rd_req     = reading;
    assign rd_addr    = addr_q;
    assign hit        = reading & rd_ack;
    assign sample.tog = rd_data[TOG_POS];
    assign sample.err = rd_data[ERR_POS];

    assign unused_data_bits = ^rd_data;

endmodule

// File: rtl/fl_poll_budget.sv
module fl_poll_budget #(
    parameter int CNT_W     = 16,
    parameter int MAX_POLLS = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             bump,
    output logic [CNT_W-1:0] count,
    output logic             last_allowed
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_POLLS - 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count_q <= '0;
        end else if (bump && (count_q != CNT_TOP)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count        = count_q;
    assign last_allowed = (count_q >= LAST_IDX);

endmodule

// File: rtl/fl_poll_ctrl.sv
module fl_poll_ctrl
    import fl_poll_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         hit,
    input  poll_sample_t sample,
    input  logic         last_allowed,
    output logic         load,
    output logic         reading,
    output logic         busy,
    output logic         done,
    output logic         pass_fail,
    output logic         timeout
);

    poll_state_e   state_q, state_d;
    poll_verdict_e verdict;
    poll_sample_t  ref_q;
    logic          launch;
    logic          finish;
    logic          done_q, pass_q, tout_q;

    assign launch = start && (state_q == PST_IDLE);

    always_comb begin
        verdict = VD_READ_ON;
        unique case (state_q)
            PST_FIRST: begin
                verdict = last_allowed ? VD_TIMEOUT : VD_READ_ON;
            end
            PST_SECOND: begin
                if (!sample_flipped(ref_q, sample)) begin
                    verdict = VD_PASS;
                end else if (last_allowed) begin
                    verdict = VD_TIMEOUT;
                end else begin
                    verdict = VD_READ_ON;
                end
            end
            PST_CONFIRM: begin
                verdict = sample_flipped(ref_q, sample) ? VD_FAIL : VD_PASS;
            end
            default: verdict = VD_READ_ON;
        endcase
    end

    assign finish = hit && verdict_final(verdict);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PST_IDLE: begin
                if (launch) state_d = PST_FIRST;
            end
            PST_FIRST: begin
                if (hit) state_d = finish ? PST_IDLE : PST_SECOND;
            end
            PST_SECOND: begin
                if (hit) begin
                    if (finish)          state_d = PST_IDLE;
                    else if (sample.err) state_d = PST_CONFIRM;
                    else                 state_d = PST_FIRST;
                end
            end
            PST_CONFIRM: begin
                if (hit) state_d = PST_IDLE;
            end
            default: state_d = PST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PST_IDLE;
            ref_q   <= '0;
            done_q  <= 1'b0;
            pass_q  <= 1'b0;
            tout_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            if (hit && (state_q != PST_CONFIRM)) begin
                ref_q <= sample;
            end
            if (launch) begin
                pass_q <= 1'b0;
                tout_q <= 1'b0;
            end else if (finish) begin
                pass_q <= (verdict == VD_PASS);
                tout_q <= (verdict == VD_TIMEOUT);
            end
        end
    end

    assign load      = launch;
    assign reading   = (state_q != PST_IDLE);
    assign busy      = (state_q != PST_IDLE);
    assign done      = done_q;
    assign pass_fail = pass_q;
    assign timeout   = tout_q;

endmodule

// File: rtl/fl_toggle_poll.sv
module fl_toggle_poll
    import fl_poll_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 16,
    parameter int MAX_POLLS = 1000,
    parameter int TOG_POS   = 6,
    parameter int ERR_POS   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              pass_fail,
    output logic              timeout,
    output logic [CNT_W-1:0]  poll_count
);

    logic         load;
    logic         reading;
    logic         hit;
    logic         last_allowed;
    poll_sample_t sample;

    fl_poll_rdport #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .TOG_POS(TOG_POS),
        .ERR_POS(ERR_POS)
    ) u_port (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_addr(start_addr),
        .reading  (reading),
        .rd_ack   (rd_ack),
        .rd_data  (rd_data),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .hit      (hit),
        .sample   (sample)
    );

    fl_poll_budget #(
        .CNT_W    (CNT_W),
        .MAX_POLLS(MAX_POLLS)
    ) u_budget (
        .clk         (clk),
        .rst         (rst),
        .clear       (load),
        .bump        (hit),
        .count       (poll_count),
        .last_allowed(last_allowed)
    );

    fl_poll_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .hit         (hit),
        .sample      (sample),
        .last_allowed(last_allowed),
        .load        (load),
        .reading     (reading),
        .busy        (busy),
        .done        (done),
        .pass_fail   (pass_fail),
        .timeout     (timeout)
    );

endmodule

// File: rtl/fl_poll_chk.sv
module fl_poll_chk #(
    parameter int ADDR_W    = 20,
    parameter int CNT_W     = 16,
    parameter int MAX_POLLS = 1000
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_req,
    input logic              rd_ack,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              busy,
    input logic              done,
    input logic              pass_fail,
    input logic              timeout,
    input logic [CNT_W-1:0]  poll_count
);

    assert_req_only_busy_R2: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> busy);

    assert_addr_held_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(rd_addr));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |->
            (poll_count == $past(poll_count) + {{(CNT_W-1){1'b0}}, $past(rd_req && rd_ack)}));

    assert_count_cap_R8: assert property (@(posedge clk) disable iff (rst)
        poll_count <= CNT_W'(MAX_POLLS));

    assert_timeout_is_fail_R8: assert property (@(posedge clk) disable iff (rst)
        timeout |-> !pass_fail);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_ack_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(rd_req && rd_ack) && !busy));

endmodule

bind fl_toggle_poll fl_poll_chk #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .MAX_POLLS(MAX_POLLS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .rd_ack    (rd_ack),
    .rd_addr   (rd_addr),
    .busy      (busy),
    .done      (done),
    .pass_fail (pass_fail),
    .timeout   (timeout),
    .poll_count(poll_count)
);

// File: tb/sim_fl_toggle_poll.sv
module sim_fl_toggle_poll;

    localparam int AW   = 16;
    localparam int DW   = 8;
    localparam int CW   = 8;
    localparam int MAXP = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          rd_ack = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          busy, done, pass_fail, timeout;
    logic [CW-1:0] poll_count;

    fl_toggle_poll #(
        .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .MAX_POLLS(MAXP),
        .TOG_POS(6), .ERR_POS(5)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .busy(busy), .done(done), .pass_fail(pass_fail), .timeout(timeout),
        .poll_count(poll_count)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    int      m_n;
    int      m_e;
    bit      m_fail;
    bit      m_phase;
    int      rd_idx = 0;
    int      lat = 0;
    int      addr_bad = 0;
    logic [AW-1:0] exp_addr = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit m_tog(input int i);
        int k;
        if (m_fail)        k = i;
        else if (m_n == 0) k = 0;
        else               k = (i < m_n - 1) ? i : m_n - 1;
        return m_phase ^ k[0];
    endfunction

    function automatic bit m_err(input int i);
        bit active;
        active = m_fail || (i < m_n);
        return active && (i >= m_e);
    endfunction

    task automatic ref_poll(output bit e_pass, output bit e_tout, output int e_reads);
        int i;
        int a;
        int b;
        i = 0;
        e_pass = 0;
        e_tout = 0;
        for (int guard = 0; guard < 1000; guard++) begin
            a = i; i++;
            if (i >= MAXP) begin e_tout = 1; break; end
            b = i; i++;
            if (m_tog(a) == m_tog(b)) begin e_pass = 1; break; end
            if (i >= MAXP) begin e_tout = 1; break; end
            if (m_err(b)) begin
                e_pass = (m_tog(i) == m_tog(b));
                i++;
                break;
            end
        end
        e_reads = i;
    endtask

    // memory responder: variable latency, data built from the flash model
    always @(negedge clk) begin
        if (rst) begin
            rd_ack = 1'b0;
            lat = 0;
        end else if (rd_ack) begin
            rd_ack = 1'b0;
            lat = int'($urandom % 3);
        end else if (rd_req) begin
            if (lat == 0) begin
                logic [DW-1:0] d;
                d = DW'($urandom);
                d[6] = m_tog(rd_idx);
                d[5] = m_err(rd_idx);
                rd_data = d;
                rd_ack = 1'b1;
                if (rd_addr !== exp_addr) addr_bad++;
                rd_idx++;
            end else begin
                lat--;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic run_case(input logic [AW-1:0] a, input int n, input int e,
                            input bit f, input bit ph, input bit poke, input string tag);
        bit e_pass, e_tout;
        int e_reads;
        int waited;
        bit got;
        int reads_at_done;
        m_n = n; m_e = e; m_fail = f; m_phase = ph;
        ref_poll(e_pass, e_tout, e_reads);
        @(negedge clk);
        rd_idx = 0; addr_bad = 0; exp_addr = a;
        start = 1'b1; start_addr = a;
        @(negedge clk);
        start = 1'b0; start_addr = ~a;
        chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        waited = 0; got = 0;
        while (!got && waited < 400) begin
            @(negedge clk);
            start = 1'b0;
            waited++;
            if (done) got = 1;
            else if (poke && waited == 2 && busy) begin
                start = 1'b1;
                start_addr = a ^ 16'h5a5a;
            end
        end
        chk(got, "R9", {tag, " done seen"}, int'(got), 1);
        chk(pass_fail == e_pass, tag, "pass_fail", int'(pass_fail), int'(e_pass));
        chk(timeout == e_tout, "R8", "timeout flag", int'(timeout), int'(e_tout));
        chk(int'(poll_count) == e_reads, "R7", "poll_count", int'(poll_count), e_reads);
        chk(rd_idx == e_reads, "R5", "reads issued", rd_idx, e_reads);
        chk(addr_bad == 0, poke ? "R3" : "R2", "address mismatches", addr_bad, 0);
        chk(busy == 1'b0, "R9", "busy low at done", int'(busy), 0);
        reads_at_done = rd_idx;
        @(negedge clk);
        chk(done == 1'b0, "R9", "done one cycle", int'(done), 0);
        repeat (2) @(negedge clk);
        chk(pass_fail == e_pass && timeout == e_tout, "R9", "result held",
            int'({pass_fail, timeout}), int'({e_pass, e_tout}));
        chk(rd_idx == reads_at_done && !busy, "R3", "no restart after run",
            rd_idx, reads_at_done);
        chk(int'(poll_count) == e_reads, "R7", "count held", int'(poll_count), e_reads);
    endtask

    initial begin
        void'($urandom(32'd2024));
        m_n = 0; m_e = 100; m_fail = 0; m_phase = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(rd_req == 0 && busy == 0 && done == 0, "R1", "control idle in reset",
            int'({rd_req, busy, done}), 0);
        chk(pass_fail == 0 && timeout == 0, "R1", "flags clear in reset",
            int'({pass_fail, timeout}), 0);
        chk(poll_count == 0, "R1", "count zero in reset", int'(poll_count), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R4: already finished, steady bit 6
        run_case(16'h1200, 0, 100, 0, 0, 0, "R4");
        run_case(16'h1201, 1, 100, 0, 1, 0, "R4");
        // R5: a few toggling reads, then steady
        run_case(16'h2000, 2, 100, 0, 0, 0, "R5");
        run_case(16'h2468, 5, 100, 0, 1, 1, "R5");
        // R6: error bit set, completion seen on confirm read -> pass
        run_case(16'h3000, 2, 1, 0, 0, 0, "R6");
        // R6: error bit set, still toggling -> fail
        run_case(16'h3100, 0, 1, 1, 1, 0, "R6");
        run_case(16'h3200, 0, 3, 1, 0, 1, "R6");
        // R8: never settles, no error -> timeout at budget
        run_case(16'h4000, 0, 100, 1, 0, 0, "R8");
        // R8: error shows on the read that exhausts the budget
        run_case(16'h4100, 0, 11, 1, 1, 0, "R8");
        // R8: completes too late
        run_case(16'h4200, 20, 100, 0, 0, 1, "R8");

        for (int t = 0; t < 40; t++) begin
            int  n, e;
            bit  f, ph, pk;
            n  = int'($urandom % 9);
            e  = int'($urandom % 12);
            f  = (($urandom % 4) == 0);
            ph = $urandom % 2;
            pk = $urandom % 2;
            run_case(AW'($urandom), n, e, f, ph, pk, "R6");
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule